// File: doc/BRIEF.md
# Ordered Store Buffer with Read Promotion

This block sits between a load/store unit and a single bus write/read port. Stores enter a four-entry FIFO while they are still speculative. A commit pulse marks the oldest speculative entry as final. Only the oldest entry can leave, and only after it has been committed, so writes reach memory in the order they were enqueued. A flush throws away every speculative entry in one cycle. Committed entries stay in the buffer and drain as usual.

The same bus port also carries read requests. A read that hits in the cache is sent ahead of pending buffered writes if no buffered store touches the bytes it reads. When a buffered store does overlap the read, the read is held until every such store has drained. A read that misses the cache waits until the buffer is completely empty. An external "write buffer empty" hint is accepted on a port but does not affect these decisions.

Top module: `store_buffer`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1 and `bus_valid` is 0 while no read is requested.
- R2: With four entries held, `st_ready` is 0. `st_ready` is also 0 in any cycle where `flush` is 1.
- R3: Writes are presented on the bus in enqueue order. Each write carries the address, data and byte enables it was enqueued with, and `bus_write` is 1. A write leaves the buffer in the cycle where it is presented and `bus_ready` is 1.
- R4: An entry that has not been committed is never presented on the bus.
- R5: Each `commit` pulse commits the oldest uncommitted entry, taking effect at the next edge. A pulse when no entry is uncommitted is ignored, and a pulse in the same cycle as `flush` is ignored.
- R6: `flush` removes every uncommitted entry at the next edge, including any store offered in that cycle. Committed entries remain and drain in order.
- R7: A read with `rd_hit`=1 that matches no buffered entry is presented on the bus (`bus_write`=0, `bus_addr`=`rd_addr`). This holds even when a committed write is pending.
- R8: A read matches an entry when both word addresses are equal and the two byte-enable masks share at least one bit. A hit read that matches any valid entry, committed or not, is not presented. The oldest committed write is presented in its place if one exists.
- R9: A read with `rd_hit`=0 is presented only when the buffer holds no entries.
- R10: `ext_wr_empty` has no effect on any output.
- R11: `rd_ready` is 1 exactly when the read is presented and `bus_ready` is 1. The read is then complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store accepted this cycle when st_valid |
| st_addr | input | 30 | Store word address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| commit | input | 1 | Commit oldest speculative store |
| flush | input | 1 | Discard all speculative stores |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read issued on the bus this cycle |
| rd_addr | input | 30 | Read word address |
| rd_be | input | 4 | Read byte enables |
| rd_hit | input | 1 | Read hits in the cache |
| ext_wr_empty | input | 1 | External write-empty hint, ignored |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | 30 | Bus word address |
| bus_data | output | 32 | Write data (0 for reads) |
| bus_be | output | 4 | Byte enables |
| bus_ready | input | 1 | Bus accepts the request this cycle |

## Verification
The bench fills the buffer and then sweeps every nonzero read byte mask against an entry that enables only its two low bytes, a fully enabled entry, and an unrelated address. Each point is tried with both hit values and both hint values, before and after the entries are committed. The sweep catches a design that compares whole words while ignoring bytes, or that ignores byte enables completely. Such a design would either hold reads that touch other bytes, or promote a read that overlaps a store. Further cases cover:
- a flush that coincides with an offered store, where a broken design keeps the new speculative store;
- a commit pulse with nothing left to commit, where a broken design would commit the next store early;
- a missed read behind a committed write, where a broken design would reorder it ahead of the write.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int unsigned SB_AW = 30;
    localparam int unsigned SB_DW = 32;
    localparam int unsigned SB_BW = SB_DW / 8;

    typedef logic [SB_AW-1:0] waddr_t;
    typedef logic [SB_DW-1:0] data_t;
    typedef logic [SB_BW-1:0] be_t;

    typedef struct packed {
        waddr_t addr;
        data_t  data;
        be_t    be;
    } store_t;

    typedef struct packed {
        logic   valid;
        logic   write;
        waddr_t addr;
        data_t  data;
        be_t    be;
    } bus_req_t;

    // Word address equal and at least one byte lane shared.
    function automatic logic overlaps(waddr_t a, be_t b, store_t e);
        return (a == e.addr) && ((b & e.be) != '0);
    endfunction

endpackage

// File: rtl/sb_queue.sv
module sb_queue
    import sb_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  store_t            push_ent,
    input  logic              pop,
    input  logic              commit,
    input  logic              flush,
    output store_t            head_ent,
    output logic              head_committed,
    output store_t            ents [DEPTH],
    output logic [DEPTH-1:0]  ent_valid,
    output logic [CW-1:0]     count,
    output logic [CW-1:0]     ccount
);

    store_t            ent_q [DEPTH];
    logic [DEPTH-1:0]  vld_q, cmt_q;
    logic [PW-1:0]     head_q, tail_q, head_n, cidx, ftail;
    logic [CW-1:0]     cnt_q, ccnt_q, ccnt_n;
    logic              do_commit;

    function automatic logic [PW-1:0] step(logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PW-1:0] wrap_add(logic [PW-1:0] p, logic [CW-1:0] n);
        int s;
        s = int'(p) + int'(n);
        if (s >= DEPTH) s = s - DEPTH;
        return PW'(s);
    endfunction

    always_comb begin
        do_commit = commit && !flush && (ccnt_q < cnt_q);
        cidx      = wrap_add(head_q, ccnt_q);
        head_n    = pop ? step(head_q) : head_q;
        ccnt_n    = ccnt_q - CW'(pop);
        ftail     = wrap_add(head_n, ccnt_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            cmt_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            ccnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            if (push) begin
                ent_q[tail_q] <= push_ent;
                vld_q[tail_q] <= 1'b1;
                cmt_q[tail_q] <= 1'b0;
            end
            if (do_commit) cmt_q[cidx] <= 1'b1;
            if (flush) begin
                for (int i = 0; i < DEPTH; i++)
                    if (!cmt_q[i]) vld_q[i] <= 1'b0;
            end
            if (pop) begin
                vld_q[head_q] <= 1'b0;
                cmt_q[head_q] <= 1'b0;
            end
            head_q <= head_n;
            if (flush) begin
                tail_q <= ftail;
                cnt_q  <= ccnt_n;
                ccnt_q <= ccnt_n;
            end else begin
                tail_q <= push ? step(tail_q) : tail_q;
                cnt_q  <= cnt_q + CW'(push) - CW'(pop);
                ccnt_q <= ccnt_q + CW'(do_commit) - CW'(pop);
            end
        end
    end

    assign head_ent       = ent_q[head_q];
    assign head_committed = vld_q[head_q] && cmt_q[head_q];
    assign ents           = ent_q;
    assign ent_valid      = vld_q;
    assign count          = cnt_q;
    assign ccount         = ccnt_q;

endmodule

// File: rtl/sb_match.sv
module sb_match
    import sb_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  store_t            ents [DEPTH],
    input  logic [DEPTH-1:0]  ent_valid,
    input  waddr_t            rd_addr,
    input  be_t               rd_be,
    output logic              match_any
);

    logic [DEPTH-1:0] hit_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = ent_valid[g] && overlaps(rd_addr, rd_be, ents[g]);
    end

    assign match_any = |hit_vec;

endmodule

// File: rtl/sb_arbiter.sv
module sb_arbiter
    import sb_pkg::*;
(
    input  logic     rd_valid,
    input  logic     rd_hit,
    input  waddr_t   rd_addr,
    input  be_t      rd_be,
    input  logic     match_any,
    input  logic     q_empty,
    input  logic     head_committed,
    input  store_t   head_ent,
    input  logic     bus_ready,
    output bus_req_t req,
    output logic     rd_grant,
    output logic     wr_pop
);

    logic rd_ok;

    // Hit reads pass pending writes unless they overlap one; misses wait for empty.
    assign rd_ok = rd_valid && (rd_hit ? !match_any : q_empty);

    always_comb begin
        req = '0;
        if (rd_ok) begin
            req.valid = 1'b1;
            req.write = 1'b0;
            req.addr  = rd_addr;
            req.be    = rd_be;
        end else if (head_committed) begin
            req.valid = 1'b1;
            req.write = 1'b1;
            req.addr  = head_ent.addr;
            req.data  = head_ent.data;
            req.be    = head_ent.be;
        end
    end

    assign rd_grant = rd_ok && bus_ready;
    assign wr_pop   = !rd_ok && head_committed && bus_ready;

endmodule

// File: rtl/store_buffer.sv
module store_buffer
    import sb_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             st_valid,
    output logic             st_ready,
    input  logic [SB_AW-1:0] st_addr,
    input  logic [SB_DW-1:0] st_data,
    input  logic [SB_BW-1:0] st_be,
    input  logic             commit,
    input  logic             flush,
    input  logic             rd_valid,
    output logic             rd_ready,
    input  logic [SB_AW-1:0] rd_addr,
    input  logic [SB_BW-1:0] rd_be,
    input  logic             rd_hit,
    input  logic             ext_wr_empty,
    output logic             bus_valid,
    output logic             bus_write,
    output logic [SB_AW-1:0] bus_addr,
    output logic [SB_DW-1:0] bus_data,
    output logic [SB_BW-1:0] bus_be,
    input  logic             bus_ready
);

    store_t            push_ent, head_ent;
    store_t            ents [DEPTH];
    logic [DEPTH-1:0]  ent_valid;
    logic [CW-1:0]     cnt_w, ccnt_w;
    logic              head_committed, match_any, wr_pop, push;
    bus_req_t          req;

    assign push_ent = '{addr: st_addr, data: st_data, be: st_be};
    assign st_ready = (cnt_w != CW'(DEPTH)) && !flush;
    assign push     = st_valid && st_ready;

    sb_queue #(.DEPTH(DEPTH)) u_queue (
        .clk            (clk),
        .rst            (rst),
        .push           (push),
        .push_ent       (push_ent),
        .pop            (wr_pop),
        .commit         (commit),
        .flush          (flush),
        .head_ent       (head_ent),
        .head_committed (head_committed),
        .ents           (ents),
        .ent_valid      (ent_valid),
        .count          (cnt_w),
        .ccount         (ccnt_w)
    );

    sb_match #(.DEPTH(DEPTH)) u_match (
        .ents      (ents),
        .ent_valid (ent_valid),
        .rd_addr   (rd_addr),
        .rd_be     (rd_be),
        .match_any (match_any)
    );

    sb_arbiter u_arb (
        .rd_valid       (rd_valid),
        .rd_hit         (rd_hit),
        .rd_addr        (rd_addr),
        .rd_be          (rd_be),
        .match_any      (match_any),
        .q_empty        (cnt_w == '0),
        .head_committed (head_committed),
        .head_ent       (head_ent),
        .bus_ready      (bus_ready),
        .req            (req),
        .rd_grant       (rd_ready),
        .wr_pop         (wr_pop)
    );

    assign bus_valid = req.valid;
    assign bus_write = req.write;
    assign bus_addr  = req.addr;
    assign bus_data  = req.data;
    assign bus_be    = req.be;

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          st_ready,
    input logic          flush,
    input logic          rd_valid,
    input logic          rd_hit,
    input logic          rd_ready,
    input logic          ext_wr_empty,
    input logic          bus_valid,
    input logic          bus_write,
    input logic          bus_ready,
    input logic [CW-1:0] q_count,
    input logic [CW-1:0] q_ccount,
    input logic          match_any
);

    AST_FULL_BLOCKS_ENQ: assert property (@(posedge clk) disable iff (rst)
        (q_count == CW'(DEPTH)) |-> !st_ready); // R2

    AST_WRITE_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write) |-> (q_ccount != '0)); // R4

    AST_COMMITTED_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        q_ccount <= q_count); // R5

    AST_FLUSH_LEAVES_COMMITTED: assert property (@(posedge clk) disable iff (rst)
        flush |=> (q_count == q_ccount)); // R6

    AST_HIT_PROMOTED: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_hit && !match_any) |-> (bus_valid && !bus_write)); // R7

    AST_OVERLAP_HELD: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_hit && match_any) |-> !(bus_valid && !bus_write)); // R8

    AST_MISS_WAITS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (rd_ready && !rd_hit) |-> (q_count == '0)); // R9

    AST_HINT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_hit && !match_any && !ext_wr_empty) |-> bus_valid); // R10

    AST_RD_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
        rd_ready |-> (rd_valid && bus_valid && !bus_write && bus_ready)); // R11

endmodule

bind store_buffer sb_checker #(.DEPTH(DEPTH)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .st_ready     (st_ready),
    .flush        (flush),
    .rd_valid     (rd_valid),
    .rd_hit       (rd_hit),
    .rd_ready     (rd_ready),
    .ext_wr_empty (ext_wr_empty),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_ready    (bus_ready),
    .q_count      (cnt_w),
    .q_ccount     (ccnt_w),
    .match_any    (match_any)
);

// File: tb/store_buffer_tb_top.sv
module store_buffer_tb_top;
    import sb_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic st_valid, st_ready, commit, flush;
    logic [SB_AW-1:0] st_addr, rd_addr, bus_addr;
    logic [SB_DW-1:0] st_data, bus_data;
    logic [SB_BW-1:0] st_be, rd_be, bus_be;
    logic rd_valid, rd_ready, rd_hit, ext_wr_empty;
    logic bus_valid, bus_write, bus_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    store_buffer dut_i (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .commit(commit), .flush(flush),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_be(rd_be), .rd_hit(rd_hit), .ext_wr_empty(ext_wr_empty),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_be(bus_be), .bus_ready(bus_ready)
    );

    task automatic check(input bit ok, input string req, input logic [95:0] act,
                         input logic [95:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic enq(input logic [SB_AW-1:0] a, input logic [SB_DW-1:0] d,
                       input logic [SB_BW-1:0] b);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = b;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic pulse_commit;
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    // Expect a write at the current sample point.
    task automatic expect_write(input string req, input logic [SB_AW-1:0] a,
                                input logic [SB_DW-1:0] d);
        check(bus_valid && bus_write && bus_addr == a && bus_data == d, req,
              {bus_valid, bus_write, bus_addr, bus_data},
              {1'b1, 1'b1, a, d});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; st_valid = 0; commit = 0; flush = 0; rd_valid = 0; rd_hit = 0;
        ext_wr_empty = 0; bus_ready = 0; st_addr = '0; st_data = '0; st_be = '0;
        rd_addr = '0; rd_be = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(st_ready && !bus_valid, "R1", {st_ready, bus_valid}, {1'b1, 1'b0});

        // Fill with four speculative stores; entry 0 enables only low two bytes.
        for (int i = 0; i < 4; i++)
            enq(30'h10 + 30'(i), 32'hA000_0000 + 32'(i), (i == 0) ? 4'b0011 : 4'b1111);
        #1;
        check(!st_ready, "R2", st_ready, 1'b0);
        check(!bus_valid, "R4", bus_valid, 1'b0);

        // Sweep read patterns, first with nothing committed, then all committed.
        for (int phase = 0; phase < 2; phase++) begin
            if (phase == 1) begin
                for (int k = 0; k < 4; k++) pulse_commit();
                #1;
                check(!st_ready, "R2", st_ready, 1'b0);
            end
            for (int ai = 0; ai < 3; ai++)
                for (int b = 1; b < 16; b++)
                    for (int h = 0; h < 2; h++)
                        for (int x = 0; x < 2; x++) begin
                            logic [SB_AW-1:0] ra;
                            bit mt, exp_rd;
                            ra = (ai == 0) ? 30'h10 : (ai == 1) ? 30'h13 : 30'h20;
                            mt = (ai == 0 && (b & 3) != 0) || (ai == 1);
                            exp_rd = (h == 1) && !mt;
                            @(negedge clk);
                            rd_valid = 1; rd_addr = ra; rd_be = 4'(b);
                            rd_hit = h[0]; ext_wr_empty = x[0];
                            #1;
                            if (exp_rd)
                                check(bus_valid && !bus_write && bus_addr == ra && bus_be == 4'(b),
                                      (x == 1) ? "R10" : "R7",
                                      {bus_valid, bus_write, bus_addr}, {1'b1, 1'b0, ra});
                            else if (phase == 0)
                                check(!bus_valid, (h == 1) ? "R8" : "R9", bus_valid, 1'b0);
                            else
                                check(bus_valid && bus_write && bus_addr == 30'h10, "R8",
                                      {bus_valid, bus_write, bus_addr}, {1'b1, 1'b1, 30'h10});
                            check(!rd_ready, "R11", rd_ready, 1'b0);
                        end
        end

        // Drain in order.
        @(negedge clk);
        rd_valid = 0; bus_ready = 1;
        for (int k = 0; k < 4; k++) begin
            #1;
            expect_write("R3", 30'h10 + 30'(k), 32'hA000_0000 + 32'(k));
            @(negedge clk);
        end
        #1;
        check(!bus_valid && st_ready, "R3", {bus_valid, st_ready}, {1'b0, 1'b1});

        // Flush: keep committed head, drop the rest and the concurrent store.
        bus_ready = 0;
        enq(30'h50, 32'hB0, 4'hF);
        enq(30'h51, 32'hB1, 4'hF);
        enq(30'h52, 32'hB2, 4'hF);
        pulse_commit();
        @(negedge clk);
        flush = 1; st_valid = 1; st_addr = 30'h60; st_data = 32'hB6; st_be = 4'hF;
        #1;
        check(!st_ready, "R2", st_ready, 1'b0);
        @(negedge clk);
        flush = 0; st_valid = 0;
        pulse_commit();                       // nothing left to commit: ignored
        enq(30'h70, 32'hB7, 4'hF);            // stays speculative
        @(negedge clk);
        bus_ready = 1;
        #1;
        expect_write("R6", 30'h50, 32'hB0);
        @(negedge clk);
        #1;
        check(!bus_valid, "R5", bus_valid, 1'b0);
        bus_ready = 0;
        pulse_commit();
        bus_ready = 1;
        #1;
        expect_write("R5", 30'h70, 32'hB7);
        @(negedge clk);
        #1;
        check(!bus_valid, "R6", bus_valid, 1'b0);

        // Miss read waits behind a committed write.
        bus_ready = 0;
        enq(30'h80, 32'hC0, 4'hF);
        pulse_commit();
        rd_valid = 1; rd_hit = 0; rd_addr = 30'h90; rd_be = 4'hF; bus_ready = 1;
        #1;
        expect_write("R9", 30'h80, 32'hC0);
        check(!rd_ready, "R9", rd_ready, 1'b0);
        @(negedge clk);
        #1;
        check(bus_valid && !bus_write && bus_addr == 30'h90 && rd_ready, "R11",
              {bus_valid, bus_write, bus_addr, rd_ready}, {1'b1, 1'b0, 30'h90, 1'b1});
        @(negedge clk);
        rd_valid = 0; bus_ready = 0;

        // Overlapping hit read held until the store drains.
        enq(30'hA0, 32'hD0, 4'hF);
        pulse_commit();
        rd_valid = 1; rd_hit = 1; rd_addr = 30'hA0; rd_be = 4'b0001; bus_ready = 1;
        #1;
        expect_write("R8", 30'hA0, 32'hD0);
        check(!rd_ready, "R8", rd_ready, 1'b0);
        @(negedge clk);
        #1;
        check(bus_valid && !bus_write && rd_ready, "R8",
              {bus_valid, bus_write, rd_ready}, {1'b1, 1'b0, 1'b1});
        @(negedge clk);
        rd_valid = 0; bus_ready = 0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule